// File: doc/BRIEF.md
# Cell-Handshake Transmit Bus Slave

This block sits on the physical-layer side of a byte-wide cell transmit bus. An upstream cell master writes fixed-length cells into it: a data byte, a start-of-cell strobe, an odd-parity bit and an active-low write enable, all taken on the rising clock edge. Flow control works on whole cells only. A single cell-available flag tells the master whether one more complete cell fits. A cell that has already started may always be finished, because its storage slot was reserved when it began.

Incoming bytes go into a ring of cell slots. A cell becomes visible downstream only after its last byte has arrived. If a new start-of-cell arrives part-way through a cell, the partial cell is thrown away and a one-cycle alignment error pulse is raised. Each stored cell keeps one sticky flag that records whether any of its bytes failed the parity check.

The read side is a valid/ready byte stream that hands out one cell at a time. While `byte_vld` is high and `byte_rdy` is low, the byte, its end marker and the cell's parity flag hold still. A byte moves on every cycle where both are high, and the cell is released after its marked last byte moves. Cells leave in the order they were completed.

Top module: `txcell_slave`

## Requirements
- R1: Inputs are taken only on rising clock edges where `tx_en_n` is 0. Any cycle with `tx_en_n` at 1 has no effect, whatever `tx_data`, `tx_soc` and `tx_par` carry.
- R2: A cell opens on an accepted byte with `tx_soc` at 1, and that byte is cell byte 0. An accepted byte with `tx_soc` at 0 while no cell is open is discarded.
- R3: A cell is CELL_BYTES bytes long (53 by default). It is committed for reading on the edge that accepts its last byte. The next cell may start on the very next edge.
- R4: Parity is odd: the count of ones across `tx_data` and `tx_par` must be odd. `cell_perr` is 1 for a stored cell if any of its bytes failed. The flag starts clear for each new cell and is 0 whenever `cell_vld` is 0.
- R5: An accepted `tx_soc` while a cell is open drops the partial cell, starts a new cell with that byte as byte 0, and raises `align_err` for exactly the one cycle after that edge.
- R6: `tx_clav` follows the current state. With no cell open it is 1 when fewer than DEPTH cells are stored. With a cell open it is 1 when fewer than DEPTH-1 cells are stored. It is 0 whenever DEPTH cells are stored.
- R7: A cell that has been opened is always completed and stored, even when `tx_clav` drops to 0 during it.
- R8: An accepted `tx_soc` while DEPTH cells are stored opens nothing, and the bytes that follow are discarded.
- R9: `cell_vld` and `byte_vld` are 1 while at least one cell is stored. Bytes are delivered in order, one per cycle with `byte_vld` and `byte_rdy` both high. `byte_eoc` marks the last byte. Outputs hold while the stream is stalled. Cells leave in completion order.
- R10: After reset no cell is stored, `tx_clav` is 1, and `align_err` and `cell_vld` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_data | input | 8 | Cell byte from the master |
| tx_soc | input | 1 | Start-of-cell, high with byte 0 |
| tx_par | input | 1 | Odd parity over `tx_data` |
| tx_en_n | input | 1 | Active-low write enable |
| tx_clav | output | 1 | One more whole cell can be accepted |
| align_err | output | 1 | One-cycle pulse: partial cell dropped |
| cell_vld | output | 1 | A complete cell is available |
| byte_vld | output | 1 | `byte_data` is valid |
| byte_rdy | input | 1 | Consumer takes the current byte |
| byte_data | output | 8 | Cell byte to the consumer |
| byte_eoc | output | 1 | Current byte is the last of its cell |
| cell_perr | output | 1 | Current cell saw a parity error |

## Verification
The bench uses the default build: 53-byte cells and a four-cell ring. Because the ring is so shallow, the full-buffer corner takes only a few hundred cycles to reach. That corner covers `tx_clav` falling in the middle of the fourth back-to-back cell, that cell still completing, and a fifth cell being refused. A parity fault is injected at the first byte, the second byte, a middle byte and the last byte. Misaligned starts, strays with no start-of-cell, enable gaps carrying a high start strobe, and a stalling consumer are each checked by comparing the data read back against an arithmetic byte pattern.

// File: rtl/txcell_pkg.sv
package txcell_pkg;
  localparam int BYTE_W = 8;

  // true when the byte and its parity bit together carry an odd count of ones
  function automatic logic odd_ok(input logic [BYTE_W-1:0] d, input logic p);
    return ^{d, p};
  endfunction
endpackage

// File: rtl/txcell_wr.sv
module txcell_wr
  import txcell_pkg::*;
#(
  parameter int CB = 53,
  parameter int IW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_soc,
  input  logic              tx_par,
  input  logic              tx_en_n,
  input  logic              room,
  output logic              wr_we,
  output logic [IW-1:0]     wr_idx,
  output logic [BYTE_W-1:0] wr_data,
  output logic              commit,
  output logic              commit_perr,
  output logic              active,
  output logic              align_err
);
  logic [IW-1:0] idx_q;
  logic          perr_q;
  logic          act_q;
  logic          err_q;
  logic          acc, bad, start_ok, cont, last;

  assign acc      = ~tx_en_n;
  assign bad      = ~odd_ok(tx_data, tx_par);
  assign start_ok = acc & tx_soc & room;
  assign cont     = acc & ~tx_soc & act_q;
  assign last     = cont & (idx_q == IW'(CB - 1));

  assign wr_we       = start_ok | cont;
  assign wr_idx      = start_ok ? '0 : idx_q;
  assign wr_data     = tx_data;
  assign commit      = last;
  assign commit_perr = perr_q | bad;
  assign active      = act_q;
  assign align_err   = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      perr_q <= 1'b0;
      act_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      err_q <= acc & tx_soc & act_q;
      if (start_ok) begin
        act_q  <= 1'b1;
        idx_q  <= IW'(1);
        perr_q <= bad;
      end else if (cont) begin
        if (last) begin
          act_q  <= 1'b0;
          idx_q  <= '0;
          perr_q <= 1'b0;
        end else begin
          idx_q  <= idx_q + 1'b1;
          perr_q <= perr_q | bad;
        end
      end else if (acc & tx_soc) begin
        act_q  <= 1'b0;
        idx_q  <= '0;
        perr_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/txcell_ring.sv
module txcell_ring
  import txcell_pkg::*;
#(
  parameter int CB    = 53,
  parameter int DEPTH = 4,
  parameter int IW    = 6,
  parameter int CW    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_we,
  input  logic [IW-1:0]     wr_idx,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              commit,
  input  logic              commit_perr,
  input  logic              wr_active,
  input  logic [IW-1:0]     rd_idx,
  input  logic              rd_done,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_perr,
  output logic [CW-1:0]     count,
  output logic              room,
  output logic              clav
);
  localparam int SW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NB = DEPTH * CB;
  localparam int AW = $clog2(NB);

  logic [BYTE_W-1:0] mem [NB];
  logic [SW-1:0]     wslot_q, rslot_q;
  logic [CW-1:0]     cnt_q;
  logic [DEPTH-1:0]  flag_q;
  logic [AW-1:0]     waddr, raddr;

  assign waddr = AW'(wslot_q) * AW'(CB) + AW'(wr_idx);
  assign raddr = AW'(rslot_q) * AW'(CB) + AW'(rd_idx);

  always_ff @(posedge clk) begin
    if (wr_we) mem[waddr] <= wr_data;
  end

  assign rd_data = mem[raddr];
  assign rd_perr = flag_q[rslot_q];

  // one parity-error flag register per cell slot
  for (genvar s = 0; s < DEPTH; s++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 flag_q[s] <= 1'b0;
      else if (commit && (wslot_q == SW'(s)))     flag_q[s] <= commit_perr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wslot_q <= '0;
      rslot_q <= '0;
      cnt_q   <= '0;
    end else begin
      if (commit)  wslot_q <= (wslot_q == SW'(DEPTH - 1)) ? '0 : wslot_q + 1'b1;
      if (rd_done) rslot_q <= (rslot_q == SW'(DEPTH - 1)) ? '0 : rslot_q + 1'b1;
      cnt_q <= cnt_q + CW'(commit) - CW'(rd_done);
    end
  end

  assign count = cnt_q;
  assign room  = int'(cnt_q) < DEPTH;
  assign clav  = wr_active ? (int'(cnt_q) + 1 < DEPTH) : room;
endmodule

// File: rtl/txcell_rd.sv
module txcell_rd #(
  parameter int CB = 53,
  parameter int IW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          avail,
  input  logic          byte_rdy,
  output logic [IW-1:0] rd_idx,
  output logic          rd_done,
  output logic          byte_eoc
);
  logic [IW-1:0] ridx_q;
  logic          fire, at_end;

  assign fire     = avail & byte_rdy;
  assign at_end   = ridx_q == IW'(CB - 1);
  assign rd_idx   = ridx_q;
  assign byte_eoc = avail & at_end;
  assign rd_done  = fire & at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ridx_q <= '0;
    else if (fire) ridx_q <= at_end ? '0 : ridx_q + 1'b1;
  end
endmodule

// File: rtl/txcell_slave.sv
module txcell_slave
  import txcell_pkg::*;
#(
  parameter int CELL_BYTES = 53,
  parameter int DEPTH      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_soc,
  input  logic              tx_par,
  input  logic              tx_en_n,
  output logic              tx_clav,
  output logic              align_err,
  output logic              cell_vld,
  output logic              byte_vld,
  input  logic              byte_rdy,
  output logic [BYTE_W-1:0] byte_data,
  output logic              byte_eoc,
  output logic              cell_perr
);
  localparam int IW = $clog2(CELL_BYTES);
  localparam int CW = $clog2(DEPTH + 1);

  logic              wr_we, commit, commit_perr, wr_active, room, rd_done, slot_perr;
  logic [IW-1:0]     wr_idx, rd_idx;
  logic [BYTE_W-1:0] wr_data;
  logic [CW-1:0]     stored_cnt;

  txcell_wr #(.CB(CELL_BYTES), .IW(IW)) u_wr (
    .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_soc(tx_soc), .tx_par(tx_par),
    .tx_en_n(tx_en_n), .room(room), .wr_we(wr_we), .wr_idx(wr_idx), .wr_data(wr_data),
    .commit(commit), .commit_perr(commit_perr), .active(wr_active), .align_err(align_err)
  );

  txcell_ring #(.CB(CELL_BYTES), .DEPTH(DEPTH), .IW(IW), .CW(CW)) u_ring (
    .clk(clk), .rst_n(rst_n), .wr_we(wr_we), .wr_idx(wr_idx), .wr_data(wr_data),
    .commit(commit), .commit_perr(commit_perr), .wr_active(wr_active), .rd_idx(rd_idx),
    .rd_done(rd_done), .rd_data(byte_data), .rd_perr(slot_perr), .count(stored_cnt),
    .room(room), .clav(tx_clav)
  );

  txcell_rd #(.CB(CELL_BYTES), .IW(IW)) u_rd (
    .clk(clk), .rst_n(rst_n), .avail(cell_vld), .byte_rdy(byte_rdy),
    .rd_idx(rd_idx), .rd_done(rd_done), .byte_eoc(byte_eoc)
  );

  assign cell_vld  = stored_cnt != '0;
  assign byte_vld  = cell_vld;
  assign cell_perr = cell_vld & slot_perr;
endmodule

// File: rtl/txcell_chk.sv
module txcell_chk #(
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_en_n,
  input logic          tx_soc,
  input logic          tx_clav,
  input logic          align_err,
  input logic          cell_vld,
  input logic          byte_vld,
  input logic          byte_rdy,
  input logic [7:0]    byte_data,
  input logic          byte_eoc,
  input logic          cell_perr,
  input logic [CW-1:0] stored
);
  a_r6_clav_low_full: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(stored) == DEPTH) |-> !tx_clav);
  a_r8_stored_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(stored) <= DEPTH);
  a_r5_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> $past(!tx_en_n && tx_soc));
  a_r9_eoc_valid: assert property (@(posedge clk) disable iff (!rst_n)
    byte_eoc |-> byte_vld);
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && !byte_rdy) |=> (byte_vld && $stable(byte_data) && $stable(byte_eoc)
                                 && $stable(cell_perr)));
  a_r9_leave_on_eoc: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cell_vld) |-> $past(byte_eoc && byte_rdy));
  a_r4_perr_gated: assert property (@(posedge clk) disable iff (!rst_n)
    cell_perr |-> cell_vld);
endmodule

bind txcell_slave txcell_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en_n(tx_en_n), .tx_soc(tx_soc), .tx_clav(tx_clav),
  .align_err(align_err), .cell_vld(cell_vld), .byte_vld(byte_vld), .byte_rdy(byte_rdy),
  .byte_data(byte_data), .byte_eoc(byte_eoc), .cell_perr(cell_perr), .stored(stored_cnt)
);

// File: tb/sim_txcell_slave.sv
module sim_txcell_slave;
  localparam int CB = 53;
  localparam int DP = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] tx_data = '0;
  logic tx_soc = 1'b0, tx_par = 1'b0, tx_en_n = 1'b1, byte_rdy = 1'b0;
  logic tx_clav, align_err, cell_vld, byte_vld, byte_eoc, cell_perr;
  logic [7:0] byte_data;

  int checks = 0, fails = 0;
  bit aerr_seen, clav_mid, done = 1'b0;

  always #4 clk = ~clk;

  txcell_slave #(.CELL_BYTES(CB), .DEPTH(DP)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_soc(tx_soc), .tx_par(tx_par),
    .tx_en_n(tx_en_n), .tx_clav(tx_clav), .align_err(align_err), .cell_vld(cell_vld),
    .byte_vld(byte_vld), .byte_rdy(byte_rdy), .byte_data(byte_data),
    .byte_eoc(byte_eoc), .cell_perr(cell_perr)
  );

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 37 + i * 11 + 5) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_cell(input int seed, input int n, input bit with_soc,
                         input int badpos, input bit gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 7 == 3)) begin
        @(negedge clk);
        aerr_seen |= align_err;
        tx_en_n = 1'b1; tx_soc = 1'b1; tx_data = 8'hA5; tx_par = 1'b0;
        @(posedge clk);
      end
      @(negedge clk);
      aerr_seen |= align_err;
      if (i == 1) clav_mid = tx_clav;
      tx_data = pat(seed, i);
      tx_par  = (~^pat(seed, i)) ^ (i == badpos);
      tx_soc  = with_soc && (i == 0);
      tx_en_n = 1'b0;
      @(posedge clk);
    end
  endtask

  task automatic idle_cyc();
    @(negedge clk);
    aerr_seen |= align_err;
    tx_en_n = 1'b1; tx_soc = 1'b0;
  endtask

  task automatic rd_cell(input int seed, input bit exp_perr, input bit gaps, input string req);
    int i = 0;
    int cyc = 0;
    while (i < CB) begin
      bit r;
      @(negedge clk);
      r = !gaps || (cyc % 3 != 2);
      cyc++;
      chk(byte_vld === 1'b1, {req, " byte_vld"}, int'(byte_vld), 1);
      chk(byte_data === pat(seed, i), {req, " data"}, int'(byte_data), int'(pat(seed, i)));
      chk(byte_eoc === (i == CB - 1), {req, " eoc"}, int'(byte_eoc), int'(i == CB - 1));
      chk(cell_perr === exp_perr, {req, " perr"}, int'(cell_perr), int'(exp_perr));
      byte_rdy = r;
      @(posedge clk);
      if (r) i++;
    end
    @(negedge clk);
    byte_rdy = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(tx_clav === 1'b1, "R10 clav", int'(tx_clav), 1);
    chk(cell_vld === 1'b0, "R10 cell_vld", int'(cell_vld), 0);
    chk(align_err === 1'b0, "R10 align_err", int'(align_err), 0);

    // R3 R6 R7: four cells back-to-back, clav sampled inside each
    aerr_seen = 1'b0;
    for (int k = 0; k < DP; k++) begin
      wr_cell(k, CB, 1'b1, -1, 1'b0);
      chk(clav_mid === (k + 1 < DP), "R6 clav inside cell", int'(clav_mid), int'(k + 1 < DP));
    end
    idle_cyc();
    chk(tx_clav === 1'b0, "R6 clav full", int'(tx_clav), 0);
    // R8: a cell offered while full is refused
    wr_cell(20, CB, 1'b1, -1, 1'b0);
    idle_cyc();
    chk(aerr_seen === 1'b0, "R3 no align error", int'(aerr_seen), 0);
    for (int k = 0; k < DP; k++) begin
      rd_cell(k, 1'b0, 1'b0, "R7 R9 ordered cell");
      chk(tx_clav === 1'b1, "R6 clav after read", int'(tx_clav), 1);
    end
    chk(cell_vld === 1'b0, "R8 refused cell absent", int'(cell_vld), 0);

    // R4: parity fault at several positions, then a clean cell
    for (int b = 0; b < 5; b++) begin
      int pos;
      pos = (b == 0) ? 0 : (b == 1) ? 1 : (b == 2) ? 26 : (b == 3) ? CB - 1 : -1;
      wr_cell(30 + b, CB, 1'b1, pos, 1'b0);
      idle_cyc();
      rd_cell(30 + b, pos >= 0, 1'b0, "R4 parity sweep");
    end

    // R5: misaligned start drops the partial cell and clears its parity flag
    aerr_seen = 1'b0;
    wr_cell(9, 20, 1'b1, 5, 1'b0);
    wr_cell(10, CB, 1'b1, -1, 1'b0);
    idle_cyc();
    chk(aerr_seen === 1'b1, "R5 align_err pulse", int'(aerr_seen), 1);
    chk(align_err === 1'b0, "R5 pulse ended", int'(align_err), 0);
    rd_cell(10, 1'b0, 1'b0, "R5 restarted cell");
    chk(cell_vld === 1'b0, "R5 partial dropped", int'(cell_vld), 0);

    // R2: stray bytes without start-of-cell are discarded
    wr_cell(11, 10, 1'b0, -1, 1'b0);
    idle_cyc();
    chk(cell_vld === 1'b0, "R2 strays ignored", int'(cell_vld), 0);
    wr_cell(12, CB, 1'b1, -1, 1'b0);
    idle_cyc();
    rd_cell(12, 1'b0, 1'b0, "R2 cell after strays");

    // R1 R9: enable gaps with soc high, and a stalling consumer
    aerr_seen = 1'b0;
    wr_cell(13, CB, 1'b1, -1, 1'b1);
    idle_cyc();
    chk(aerr_seen === 1'b0, "R1 gaps ignored", int'(aerr_seen), 0);
    rd_cell(13, 1'b0, 1'b1, "R1 R9 gapped write stalled read");
    chk(cell_vld === 1'b0, "R9 empty at end", int'(cell_vld), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule